// File: doc/BRIEF.md
# Paged Edge-Detect Interrupt Controller

This block watches the first three byte-wide ports of a general-purpose I/O bank (24 lines by default) for level changes. It then raises one interrupt line whenever any enabled line has seen an edge in the direction software chose for it. Each line has three configuration bits: a polarity bit, an enable bit and a sticky event flag. All three banks share one three-byte register window, and a 2-bit page field in a page/lock control register picks which bank that window shows. A read-only summary register reports which of the three ports holds at least one pending event, so an interrupt handler can skip ports that are quiet.

Pin levels enter asynchronously and pass through a synchroniser. An edge is found by comparing the synchronised level with its value one cycle earlier. A detected, enabled edge sets the line's event flag, and the flag stays set until software writes a zero to that bit through the flag page. The port drive logic is outside this block. The block only supplies the lock bits that guard it and a per-port write strobe that those bits gate. The host bus is reduced to a single-cycle write strobe and a combinational read path.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the page/lock register, the polarity bank, the enable bank and the flag bank read zero, the summary reads zero, `irq_o` is low and no port strobe is active.
- R2: Offset 0x07 holds the page/lock register and reads back all eight written bits. Bits 7:6 are the page (1 = polarity, 2 = enable, 3 = event flags) and bits 5:0 are the lock bits of ports 0..5, also driven on `port_lock_o`.
- R3: On pages 1 and 2, offsets 0x08, 0x09 and 0x0A read and write byte n of the polarity or enable bank, where byte n covers lines 8n..8n+7 with line 8n in bit 0. On page 0 those offsets read zero and writes to them change nothing.
- R4: On an enabled line with polarity bit 1, a rising edge sets the event flag and a falling edge does not. The flag reads as set after the third rising clock edge following the pin change and not after the second.
- R5: On an enabled line with polarity bit 0, a falling edge sets the event flag and a rising edge does not.
- R6: An edge on a line whose enable bit is 0 never sets its event flag.
- R7: An event flag stays set until it is cleared. On page 3, a write to offset 0x08+n clears every flag of byte n whose written bit is 0 and leaves the flags under written 1 bits unchanged.
- R8: When an edge is detected in the same cycle as a write that clears that byte, the new event's flag ends up set, while the other cleared flags end up clear.
- R9: Offset 0x06 reads the pending summary: bit n is 1 exactly when any event flag of byte n is set, and bits 7:3 are zero.
- R10: `irq_o` is high exactly when at least one event flag is set.
- R11: A write to offset n in 0..5 pulses `port_wr_o[n]` for that cycle unless lock bit n is set, in which case no strobe appears.
- R12: Reads at offsets 0x00 to 0x05 and 0x0B to 0x0F return zero on every page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_lvl | input | 24 | Raw pin levels of the edge-capable lines (asynchronous) |
| port_wr_o | output | 6 | Per-port write strobes for the port drive logic, gated by the lock bits |
| port_lock_o | output | 6 | Current lock bits |
| irq_o | output | 1 | Interrupt request, high while any event flag is set |

## Verification
The main sweep takes every one of the 24 lines under both polarities and moves it through a qualifying edge and then the opposite edge, with all other lines held still. This separates a correct line and byte mapping from a shifted or swapped one, rising from falling, and a sticky flag from one that follows the pin. It also fixes the exact detection latency. Smaller patterns then toggle all lines with the enables cleared and with a single line enabled, which shows whether gating is per line. A partial clear mask shows whether clearing is per bit. A clear timed to land in the same cycle as a new edge shows which of the two wins. Lock patterns and reads at unmapped offsets check the address decode on each page.

// File: rtl/eic_pkg.sv
// Shared constants and types for the paged edge-detect interrupt controller.
// Assumes byte-wide registers and a fixed 16-offset register space.
package eic_pkg;
    localparam int BYTE_W    = 8;
    localparam int ALL_PORTS = 6;
    localparam int ADDR_W    = 4;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_ENA  = 2'd2,
        PG_FLAG = 2'd3
    } page_e;

    localparam logic [ADDR_W-1:0] OFF_SUMMARY = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_PAGECTL = 4'h7;
    localparam logic [1:0]        WIN_UPPER   = 2'b10;
endpackage

// File: rtl/eic_edge_sense.sv
// Synchronises raw pin levels and flags rising and falling transitions.
// Assumes pins are asynchronous. The chain resets low, so a pin that is
// already high at reset shows one rising edge once reset is released.
module eic_edge_sense #(
    parameter int LINES  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    logic [STAGES-1:0][LINES-1:0] chain_q;
    logic [LINES-1:0]             prev_q;
    logic [LINES-1:0]             level;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of the pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i;
            end
        end else begin : g_multi
            // Multi-flop shift chain for metastability settling.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];

    // Hold the settled level of the previous cycle for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Transition detection against the previous settled level.
    always_comb begin
        rise_o = level & ~prev_q;
        fall_o = ~level & prev_q;
    end
endmodule

// File: rtl/eic_bank_regs.sv
// Holds the page/lock register and the polarity, enable and event-flag
// banks, decodes the three-byte paged window and keeps the sticky flags.
// Assumes EDGE_PORTS is at most 3, the size of the window.
module eic_bank_regs
    import eic_pkg::*;
#(
    parameter int EDGE_PORTS = 3,
    localparam int LINES     = EDGE_PORTS * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    input  logic [LINES-1:0]      rise_i,
    input  logic [LINES-1:0]      fall_i,
    output page_e                 page_o,
    output logic [ALL_PORTS-1:0]  lock_o,
    output logic [LINES-1:0]      pol_o,
    output logic [LINES-1:0]      en_o,
    output logic [LINES-1:0]      flag_o,
    output logic                  win_hit_o,
    output logic [1:0]            win_idx_o
);
    logic             ctl_wr;
    logic             bank_wr;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] flag_nx;
    int               base;

    // Window decode: offsets 0x08 upward, one per edge-capable port.
    always_comb begin
        win_idx_o = addr_i[1:0];
        win_hit_o = (addr_i[3:2] == WIN_UPPER) && (int'(addr_i[1:0]) < EDGE_PORTS);
        base      = int'(addr_i[1:0]) * BYTE_W;
        ctl_wr    = wr_i && (addr_i == OFF_PAGECTL);
        bank_wr   = wr_i && win_hit_o;
    end

    // Page field and port lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_o <= PG_NONE;
            lock_o <= '0;
        end else if (ctl_wr) begin
            page_o <= page_e'(wdata_i[7:6]);
            lock_o <= wdata_i[ALL_PORTS-1:0];
        end
    end

    // Polarity bank, written through page 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pol_o <= '0;
        else if (bank_wr && page_o == PG_POL) pol_o[base +: BYTE_W] <= wdata_i;
    end

    // Enable bank, written through page 2.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_o <= '0;
        else if (bank_wr && page_o == PG_ENA) en_o[base +: BYTE_W] <= wdata_i;
    end

    // Qualified events: enabled lines with an edge of the chosen direction.
    always_comb begin
        hit = en_o & ((pol_o & rise_i) | (~pol_o & fall_i));
    end

    // Next flag state: apply the clear mask first, then let new events win.
    always_comb begin
        flag_nx = flag_o;
        if (bank_wr && page_o == PG_FLAG)
            flag_nx[base +: BYTE_W] = flag_o[base +: BYTE_W] & wdata_i;
        flag_nx = flag_nx | hit;
    end

    // Sticky event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= flag_nx;
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
// Top of the paged edge-detect interrupt controller: ties the synchroniser
// and the register banks together, forms the per-port summary, the
// interrupt line, the lock-gated port strobes and the read mux.
// Assumes a single-cycle write strobe and a combinational read.
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int EDGE_PORTS  = 3,
    parameter int SYNC_STAGES = 2,
    localparam int LINES      = EDGE_PORTS * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [LINES-1:0]      pin_lvl,
    output logic [ALL_PORTS-1:0]  port_wr_o,
    output logic [ALL_PORTS-1:0]  port_lock_o,
    output logic                  irq_o
);
    logic [LINES-1:0]      rise;
    logic [LINES-1:0]      fall;
    page_e                 page_q;
    logic [ALL_PORTS-1:0]  lock_q;
    logic [LINES-1:0]      pol_q;
    logic [LINES-1:0]      en_q;
    logic [LINES-1:0]      flag_q;
    logic                  win_hit;
    logic [1:0]            win_idx;
    logic [EDGE_PORTS-1:0] summary;
    int                    rbase;

    eic_edge_sense #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    eic_bank_regs #(.EDGE_PORTS(EDGE_PORTS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rise_i    (rise),
        .fall_i    (fall),
        .page_o    (page_q),
        .lock_o    (lock_q),
        .pol_o     (pol_q),
        .en_o      (en_q),
        .flag_o    (flag_q),
        .win_hit_o (win_hit),
        .win_idx_o (win_idx)
    );

    generate
        for (genvar k = 0; k < EDGE_PORTS; k++) begin : g_sum
            // Port k is pending while any of its eight flags is set.
            assign summary[k] = |flag_q[k*BYTE_W +: BYTE_W];
        end
        for (genvar p = 0; p < ALL_PORTS; p++) begin : g_strobe
            // Port register write strobe, suppressed by its lock bit.
            assign port_wr_o[p] = bus_wr && (bus_addr == ADDR_W'(p)) && !lock_q[p];
        end
    endgenerate

    assign irq_o       = |flag_q;
    assign port_lock_o = lock_q;

    // Read mux: summary, page/lock, then the bank the page selects.
    always_comb begin
        bus_rdata = '0;
        rbase     = int'(win_idx) * BYTE_W;
        if (bus_addr == OFF_SUMMARY) begin
            bus_rdata = {{(BYTE_W-EDGE_PORTS){1'b0}}, summary};
        end else if (bus_addr == OFF_PAGECTL) begin
            bus_rdata = {page_q, lock_q};
        end else if (win_hit) begin
            case (page_q)
                PG_POL:  bus_rdata = pol_q[rbase +: BYTE_W];
                PG_ENA:  bus_rdata = en_q[rbase +: BYTE_W];
                PG_FLAG: bus_rdata = flag_q[rbase +: BYTE_W];
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/eic_checker.sv
// Temporal checks on the paged edge-detect interrupt controller, bound to
// its top. Assumes synchronous active-low reset.
module eic_checker
    import eic_pkg::*;
#(
    parameter int EDGE_PORTS = 3,
    localparam int LINES     = EDGE_PORTS * BYTE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [1:0]            page,
    input logic [LINES-1:0]      pol,
    input logic [LINES-1:0]      en,
    input logic [LINES-1:0]      flag,
    input logic [EDGE_PORTS-1:0] summary,
    input logic [ALL_PORTS-1:0]  lock,
    input logic [ALL_PORTS-1:0]  port_wr,
    input logic                  irq
);
    logic in_win;
    logic flag_clr_wr;

    // Independent decode of window accesses.
    always_comb begin
        in_win      = (bus_addr >= 4'h8) && (bus_addr < 4'(8 + EDGE_PORTS));
        flag_clr_wr = bus_wr && in_win && (page == 2'd3);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag == '0 && !irq));

    p_page0_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_win && page == 2'd0) |=> ($stable(pol) && $stable(en)));

    p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag & ~$past(flag) & ~$past(en)) == '0);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flag_clr_wr) |-> (($past(flag) & ~flag) == '0));

    p_irq_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (summary != '0));

    p_lock_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr & lock) == '0);
endmodule

bind edge_irq_ctrl eic_checker #(.EDGE_PORTS(EDGE_PORTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .page     (page_q),
    .pol      (pol_q),
    .en       (en_q),
    .flag     (flag_q),
    .summary  (summary),
    .lock     (lock_q),
    .port_wr  (port_wr_o),
    .irq      (irq_o)
);

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_lvl = '0;
    logic [5:0]  port_wr_o;
    logic [5:0]  port_lock_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_lvl     (pin_lvl),
        .port_wr_o   (port_wr_o),
        .port_lock_o (port_lock_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_bank(input logic [1:0] pg, input logic [23:0] v);
        wr(4'h7, {pg, 6'b0});
        wr(4'h8, v[7:0]);
        wr(4'h9, v[15:8]);
        wr(4'hA, v[23:16]);
    endtask

    // Reads the three window bytes on the page currently selected.
    task automatic rd_win(output logic [23:0] v);
        logic [7:0] b;
        rd(4'h8, b); v[7:0]   = b;
        rd(4'h9, b); v[15:8]  = b;
        rd(4'hA, b); v[23:16] = b;
    endtask

    task automatic get_bank(input logic [1:0] pg, output logic [23:0] v);
        wr(4'h7, {pg, 6'b0});
        rd_win(v);
    endtask

    initial begin
        #800000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] v;
        logic        start;
        logic        p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'h7, b); chk("R1 pagectl", b, 8'h00);
        rd(4'h6, b); chk("R1 summary", b, 8'h00);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 strobes", port_wr_o, 6'h00);
        get_bank(2'd1, v); chk("R1 pol", v, 24'h0);
        get_bank(2'd2, v); chk("R1 en", v, 24'h0);
        get_bank(2'd3, v); chk("R1 flags", v, 24'h0);

        // R2: page/lock readback
        wr(4'h7, 8'hAA); rd(4'h7, b); chk("R2 readback", b, 8'hAA);
        chk("R2 lock out", port_lock_o, 6'h2A);
        wr(4'h7, 8'h00);

        // R3: bank readback and page-0 isolation
        set_bank(2'd1, 24'h563412);
        set_bank(2'd2, 24'hC3A50F);
        get_bank(2'd1, v); chk("R3 pol bytes", v, 24'h563412);
        get_bank(2'd2, v); chk("R3 en bytes", v, 24'hC3A50F);
        set_bank(2'd0, 24'hFFFFFF);
        rd_win(v); chk("R3 page0 read", v, 24'h0);
        get_bank(2'd1, v); chk("R3 page0 pol kept", v, 24'h563412);
        get_bank(2'd2, v); chk("R3 page0 en kept", v, 24'hC3A50F);

        // R12: unmapped offsets read zero on every page
        for (int pg = 0; pg < 4; pg++) begin
            wr(4'h7, {2'(pg), 6'b0});
            for (int a = 0; a < 16; a++) begin
                if (a < 6 || a > 10) begin
                    rd(4'(a), b);
                    chk($sformatf("R12 page %0d offset %0d", pg, a), b, 8'h00);
                end
            end
        end

        // R11: lock-gated port strobes
        wr(4'h7, 8'b00_010101);
        chk("R11 lock out", port_lock_o, 6'b010101);
        for (int a = 0; a < 6; a++) begin
            @(negedge clk);
            bus_addr = 4'(a); bus_wdata = 8'h5A; bus_wr = 1'b1;
            #1;
            chk($sformatf("R11 strobe %0d", a), port_wr_o,
                ((6'b010101 >> a) & 6'b1) != 0 ? 6'h00 : (6'h01 << a));
            @(negedge clk);
            bus_wr = 1'b0;
        end
        wr(4'h7, 8'h00);

        // R4 R5 R7 R9 R10: every line, both polarities
        for (int pi = 0; pi < 2; pi++) begin
            for (int L = 0; L < 24; L++) begin
                p = pi[0];
                start = ~p;
                set_bank(2'd2, 24'h0);
                pin_lvl = {24{start}};
                repeat (4) @(negedge clk);
                set_bank(2'd1, {24{p}});
                set_bank(2'd2, 24'hFFFFFF);
                set_bank(2'd3, 24'h0);
                pin_lvl[L] = ~start;
                @(negedge clk); @(negedge clk);
                rd(4'(8 + L / 8), b);
                chk($sformatf("%s latency line %0d", p ? "R4" : "R5", L), b, 8'h00);
                @(negedge clk);
                rd(4'(8 + L / 8), b);
                chk($sformatf("%s set line %0d", p ? "R4" : "R5", L), b, 8'h01 << (L % 8));
                rd_win(v);
                chk($sformatf("%s only line %0d", p ? "R4" : "R5", L), v, 24'h1 << L);
                rd(4'h6, b);
                chk($sformatf("R9 summary line %0d", L), b, 8'h01 << (L / 8));
                chk($sformatf("R10 irq line %0d", L), irq_o, 1'b1);
                pin_lvl[L] = start;
                repeat (4) @(negedge clk);
                rd_win(v);
                chk($sformatf("R7 sticky, %s opposite edge ignored line %0d", p ? "R4" : "R5", L),
                    v, 24'h1 << L);
                wr(4'(8 + L / 8), 8'h00);
                rd_win(v);
                chk($sformatf("R7 clear line %0d", L), v, 24'h0);
                chk($sformatf("R10 irq low line %0d", L), irq_o, 1'b0);
            end
        end

        // R6: disabled lines stay silent
        set_bank(2'd2, 24'h0);
        pin_lvl = '0;
        repeat (4) @(negedge clk);
        set_bank(2'd1, 24'hFFFFFF);
        set_bank(2'd3, 24'h0);
        pin_lvl = '1; repeat (5) @(negedge clk);
        pin_lvl = '0; repeat (5) @(negedge clk);
        rd_win(v); chk("R6 all disabled", v, 24'h0);
        chk("R6 irq", irq_o, 1'b0);
        set_bank(2'd2, 24'h000020);
        wr(4'h7, 8'hC0);
        pin_lvl = '1; repeat (5) @(negedge clk);
        rd_win(v); chk("R6 single enabled", v, 24'h000020);
        wr(4'h8, 8'h00);

        // R7: per-bit clear mask; R9 multi-port summary
        set_bank(2'd2, 24'hFFFFFF);
        pin_lvl = '0; repeat (4) @(negedge clk);
        set_bank(2'd3, 24'h0);
        pin_lvl[1] = 1'b1; pin_lvl[2] = 1'b1; pin_lvl[20] = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'h6, b); chk("R9 two ports", b, 8'h05);
        wr(4'h8, 8'hFB);
        rd_win(v); chk("R7 partial clear", v, 24'h100002);
        rd(4'h6, b); chk("R9 after partial", b, 8'h05);
        wr(4'h8, 8'h00); wr(4'hA, 8'h00);
        rd(4'h6, b); chk("R9 cleared", b, 8'h00);

        // R8: event coincides with a clear of its byte
        pin_lvl = '0; repeat (4) @(negedge clk);
        set_bank(2'd3, 24'h0);
        pin_lvl[9] = 1'b1; repeat (4) @(negedge clk);
        pin_lvl[10] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_addr = 4'h9; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'h9, b); chk("R8 edge beats clear", b, 8'h04);
        wr(4'h9, 8'h00);
        rd(4'h9, b); chk("R8 cleared after", b, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule